// File: doc/BRIEF.md
# LIN Slave Autobaud Measurement Unit

This unit lets a LIN slave lock onto the master's bit rate. Once the break detector has seen a break, it pulses a start strobe. The unit then waits for the sync byte 0x55 and times it. That byte is sent least significant bit first between a start bit and a stop bit, so it gives five falling edges spaced two bit times apart. The clock cycles between the first and the fifth falling edge span exactly eight bit times. That count, divided by eight, becomes the new baud divisor, and a completion flag is raised.

The measurement counter saturates instead of wrapping. If it reaches its ceiling before the fifth falling edge arrives, the activity on the line was not a sync byte or the master is too slow. The unit then raises both the error flag and the completion flag and keeps the old divisor. Each flag is cleared by a read strobe of its own. The completion flag can request a receive interrupt. In master mode the unit is idle and its completion flag reads as zero.

Top module: `lin_autobaud`

## Requirements
- R1: After reset, `divisor` equals the parameter `DIV_RESET` (104 by default), and `abDone`, `abErr` and `rxIrq` are all 0.
- R2: In slave mode, after a start strobe, `divisor` is loaded with the number of clock cycles from the first to the fifth falling edge of `rxIn`, shifted right by 3. `abDone` is 1 after the clock edge that samples the fifth falling edge.
- R3: The 16-bit measurement counter saturates at 0xFFFF. If it reaches 0xFFFF and one more cycle passes without the fifth falling edge, `abErr` and `abDone` are both set and `divisor` is unchanged.
- R4: When `slaveMode` is 0, `abDone` reads 0, start strobes are ignored and `divisor` does not change.
- R5: `rxIrq` is 1 exactly when `abDone` is 1 and `abIntEn` is 1.
- R6: A one-cycle pulse on `rdStatus0` clears `abDone` and leaves `abErr` unchanged.
- R7: A one-cycle pulse on `rdRxData` clears `abErr` and leaves `abDone` unchanged.
- R8: If a clear strobe and the event that sets the same flag fall in the same cycle, the set wins.
- R9: Falling edges on `rxIn` with no start strobe before them start no measurement: `divisor` and `abDone` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxIn | input | 1 | Receive line, already synchronized to `clk` |
| slaveMode | input | 1 | 1 = slave (measurement enabled), 0 = master |
| abIntEn | input | 1 | Enables the interrupt request on completion |
| abStart | input | 1 | One-cycle strobe from the break detector that arms a measurement |
| rdStatus0 | input | 1 | Strobe for a read of the status register; clears `abDone` |
| rdRxData | input | 1 | Strobe for a read of the receive data register; clears `abErr` |
| divisor | output | 16 | Baud divisor: measured bit period in clock cycles |
| abDone | output | 1 | Autobaud completion flag |
| abErr | output | 1 | Autobaud overrun/error flag |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The assertions check the cycle-level rules on every cycle. In master mode the completion flag stays low and the divisor holds. The interrupt request never appears without its enable. Each flag holds until its own read strobe arrives. The divisor does not move in the cycle an overflow is reported. Only the bench's scenarios show that the measured value is correct over a range of bit periods, that the counter overflows after a long low line, that set beats clear, and that edges without a start strobe are ignored.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic loadDiv;
    logic setDone;
    logic setErr;
  } abdStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_MEAS = 2'd2
  } abdState_t;
endpackage

// File: rtl/abd_ctrl.sv
module abd_ctrl
  import abd_pkg::*;
#(
  parameter int SYNC_BITS = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxIn,
  input  logic     slaveMode,
  input  logic     abStart,
  input  logic     cntFull,
  output abdStrb_t strb
);
  localparam int FALLS = SYNC_BITS / 2;
  localparam int EW = (FALLS > 1) ? $clog2(FALLS) : 1;
  localparam logic [EW-1:0] LAST_EDGE = EW'(FALLS - 1);

  abdState_t state, stateNxt;
  logic [EW-1:0] edgeCnt, edgeNxt;
  logic rxPrev;
  logic fallSeen;

  assign fallSeen = rxPrev & ~rxIn;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    edgeNxt  = edgeCnt;
    if (!slaveMode) begin
      stateNxt = ST_IDLE;
    end else if (abStart) begin
      stateNxt = ST_ARM;
      edgeNxt  = '0;
    end else begin
      unique case (state)
        ST_ARM: begin
          if (fallSeen) begin
            stateNxt    = ST_MEAS;
            strb.clrCnt = 1'b1;
            edgeNxt     = '0;
          end
        end
        ST_MEAS: begin
          if (fallSeen && edgeCnt == LAST_EDGE) begin
            strb.loadDiv = 1'b1;
            strb.setDone = 1'b1;
            stateNxt     = ST_IDLE;
          end else if (cntFull) begin
            strb.setErr  = 1'b1;
            strb.setDone = 1'b1;
            stateNxt     = ST_IDLE;
          end else begin
            strb.incCnt = 1'b1;
            if (fallSeen) edgeNxt = edgeCnt + 1'b1;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      edgeCnt <= '0;
      rxPrev  <= 1'b1;
    end else begin
      state   <= stateNxt;
      edgeCnt <= edgeNxt;
      rxPrev  <= rxIn;
    end
  end
endmodule

// File: rtl/abd_dpath.sv
module abd_dpath
  import abd_pkg::*;
#(
  parameter int          CNT_W     = 16,
  parameter int          SYNC_BITS = 8,
  parameter logic [15:0] DIV_RESET = 16'd104
) (
  input  logic             clk,
  input  logic             rstN,
  input  abdStrb_t         strb,
  input  logic             rdStatus0,
  input  logic             rdRxData,
  output logic             cntFull,
  output logic [CNT_W-1:0] divisor,
  output logic             doneFlag,
  output logic             errFlag
);
  localparam int SHIFT = $clog2(SYNC_BITS);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   total;
  logic [CNT_W:0]   scaled;

  assign cntFull = &cnt;
  assign total   = {1'b0, cnt} + 1'b1;
  assign scaled  = total >> SHIFT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.clrCnt) begin
      cnt <= '0;
    end else if (strb.incCnt && !cntFull) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divisor <= CNT_W'(DIV_RESET);
    end else if (strb.loadDiv) begin
      divisor <= scaled[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (strb.setDone)  doneFlag <= 1'b1;
      else if (rdStatus0) doneFlag <= 1'b0;
      if (strb.setErr)   errFlag <= 1'b1;
      else if (rdRxData) errFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/lin_autobaud.sv
module lin_autobaud
  import abd_pkg::*;
#(
  parameter int          CNT_W     = 16,
  parameter int          SYNC_BITS = 8,
  parameter logic [15:0] DIV_RESET = 16'd104
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  logic             slaveMode,
  input  logic             abIntEn,
  input  logic             abStart,
  input  logic             rdStatus0,
  input  logic             rdRxData,
  output logic [CNT_W-1:0] divisor,
  output logic             abDone,
  output logic             abErr,
  output logic             rxIrq
);
  abdStrb_t strb;
  logic cntFull;
  logic doneFlag;
  logic errFlag;

  abd_ctrl #(.SYNC_BITS(SYNC_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .slaveMode(slaveMode),
    .abStart(abStart), .cntFull(cntFull), .strb(strb)
  );

  abd_dpath #(.CNT_W(CNT_W), .SYNC_BITS(SYNC_BITS), .DIV_RESET(DIV_RESET)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rdStatus0(rdStatus0),
    .rdRxData(rdRxData), .cntFull(cntFull), .divisor(divisor),
    .doneFlag(doneFlag), .errFlag(errFlag)
  );

  assign abDone = doneFlag & slaveMode;
  assign abErr  = errFlag;
  assign rxIrq  = abDone & abIntEn;
endmodule

// File: rtl/abd_checker.sv
module abd_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             slaveMode,
  input logic             abIntEn,
  input logic             rdStatus0,
  input logic             rdRxData,
  input logic [CNT_W-1:0] divisor,
  input logic             abDone,
  input logic             abErr,
  input logic             rxIrq
);
  p_master_done_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    !slaveMode |-> !abDone);

  p_master_div_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !slaveMode |=> $stable(divisor));

  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (abIntEn && abDone));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (abDone && !rdStatus0 && slaveMode) |=> (abDone || !slaveMode));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (abErr && !rdRxData) |=> abErr);

  p_overflow_keeps_div_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abErr) |-> $stable(divisor));
endmodule

bind lin_autobaud abd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .slaveMode(slaveMode), .abIntEn(abIntEn),
  .rdStatus0(rdStatus0), .rdRxData(rdRxData), .divisor(divisor),
  .abDone(abDone), .abErr(abErr), .rxIrq(rxIrq)
);

// File: tb/sim_lin_autobaud.sv
`timescale 1ns/1ps
module sim_lin_autobaud;
  localparam logic [15:0] RST_DIV = 16'd104;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic slaveMode = 1'b1;
  logic abIntEn = 1'b0;
  logic abStart = 1'b0;
  logic rdStatus0 = 1'b0;
  logic rdRxData = 1'b0;
  logic [15:0] divisor;
  logic abDone, abErr, rxIrq;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  logic [15:0] lastDiv;

  always #4 clk = ~clk;

  lin_autobaud #(.CNT_W(16), .SYNC_BITS(8), .DIV_RESET(RST_DIV)) u0 (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .slaveMode(slaveMode),
    .abIntEn(abIntEn), .abStart(abStart), .rdStatus0(rdStatus0),
    .rdRxData(rdRxData), .divisor(divisor), .abDone(abDone),
    .abErr(abErr), .rxIrq(rxIrq)
  );

  function automatic logic [15:0] expDivisor(int bitCycles);
    int span;
    span = 8 * bitCycles;
    return 16'(span >> 3);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    abStart = 1'b1;
    @(negedge clk);
    abStart = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendSync(int p, bit rdAtLast);
    for (int b = 0; b < 10; b++) begin
      rxIn = (b % 2 == 1);
      if (rdAtLast && b == 8) rdStatus0 = 1'b1;
      for (int c = 0; c < p; c++) begin
        @(negedge clk);
        rdStatus0 = 1'b0;
      end
    end
  endtask

  task automatic readStatus();
    rdStatus0 = 1'b1;
    @(negedge clk);
    rdStatus0 = 1'b0;
  endtask

  task automatic readData();
    rdRxData = 1'b1;
    @(negedge clk);
    rdRxData = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=%0d expected<200000 cycles", cycles);
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 divisor", divisor, RST_DIV);
    check("R1 abDone", abDone, 0);
    check("R1 abErr", abErr, 0);
    check("R1 rxIrq", rxIrq, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R9 edges without a start strobe
    sendSync(6, 1'b0);
    check("R9 divisor", divisor, RST_DIV);
    check("R9 abDone", abDone, 0);

    // R2 directed short period
    pulseStart();
    sendSync(4, 1'b0);
    check("R2 divisor p4", divisor, expDivisor(4));
    check("R2 abDone", abDone, 1);
    check("R5 irq disabled", rxIrq, 0);
    abIntEn = 1'b1;
    @(negedge clk);
    check("R5 irq enabled", rxIrq, 1);
    readStatus();
    check("R6 done cleared", abDone, 0);
    check("R5 irq follows", rxIrq, 0);

    // R2 and R5 random periods
    for (int i = 0; i < 8; i++) begin
      int p;
      bit en;
      p  = 2 + int'($urandom % 300);
      en = 1'($urandom % 2);
      abIntEn = en;
      pulseStart();
      sendSync(p, 1'b0);
      check("R2 random divisor", divisor, expDivisor(p));
      check("R2 random done", abDone, 1);
      check("R5 random irq", rxIrq, en);
      readStatus();
    end
    abIntEn = 1'b0;

    // R8 clear and set in the same cycle
    pulseStart();
    sendSync(10, 1'b1);
    check("R8 set beats clear", abDone, 1);
    check("R8 divisor", divisor, expDivisor(10));
    readStatus();

    // R4 master mode
    lastDiv = divisor;
    slaveMode = 1'b0;
    @(negedge clk);
    pulseStart();
    sendSync(20, 1'b0);
    check("R4 master done", abDone, 0);
    check("R4 master divisor", divisor, lastDiv);
    slaveMode = 1'b1;
    @(negedge clk);
    check("R4 no hidden done", abDone, 0);

    // R3 overflow on a line held low
    lastDiv = divisor;
    pulseStart();
    rxIn = 1'b0;
    repeat (65530) @(negedge clk);
    check("R3 no early err", abErr, 0);
    repeat (20) @(negedge clk);
    check("R3 err set", abErr, 1);
    check("R3 done set", abDone, 1);
    check("R3 divisor kept", divisor, lastDiv);
    rxIn = 1'b1;
    @(negedge clk);

    // R6 status read leaves err
    readStatus();
    check("R6 done clear", abDone, 0);
    check("R6 err kept", abErr, 1);

    // R7 data read clears err only
    pulseStart();
    sendSync(5, 1'b0);
    check("R7 done before read", abDone, 1);
    readData();
    check("R7 err cleared", abErr, 0);
    check("R7 done kept", abDone, 1);

    finishRun();
  end
endmodule